// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks the line reservations behind load-linked and store-conditional operations. It sits where write-class operations complete. Each completion carries a line address, an operation code and a requester ID. The block updates one reservation register per requester. For every completion it returns a result word: 1 for success and 0 for a failed store-conditional. It also gives the cache controller's request queue a one-cycle block pulse when a locked read-modify-write read completes, and a one-cycle unblock pulse when the matching locked write completes.

Completions enter on a valid/ready stream, and results leave on a second valid/ready stream. The block holds at most one result. While that result is held and `res_ready` is low, `cmp_ready` stays low, so back-pressure on the result side stalls the completion side in the same cycle. An external snoop input reports invalidation or eviction of a line. A test-mode pin bypasses all reservation handling.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, no reservation is valid, `res_valid`, `q_block` and `q_unblock` are 0, and `cmp_ready` is 1.
- R2: A completion is accepted in a cycle where `cmp_valid` and `cmp_ready` are both high.
  - Its result appears on `res_valid`/`res_data`/`res_id` after that clock edge.
  - The result stays stable until it is taken with `res_ready`.
  - `cmp_ready` is low while an untaken result is held and `res_ready` is low.
- R3: Operation codes on `cmp_op` are: 0 store, 1 read-modify-write read, 2 read-modify-write write, 3 load-linked, 4 store-conditional, 5 locked read-modify-write read, 6 locked read-modify-write write. Code 7 behaves as a store.
- R4: A load-linked sets the requester's reservation to its line and replaces any earlier reservation of that requester. Its result is 1.
- R5: A store-conditional returns 1 only if the requester holds a valid reservation on the same line. Otherwise it returns 0.
- R6: Every store-conditional clears all reservations on its line, whether it succeeds or fails. A reservation on a different line is kept.
- R7: Codes 0, 1, 2, 5, 6 and 7 return 1.
  - They clear the requester's own reservation when it is on the same line.
  - They leave reservations of other requesters untouched.
- R8: A locked read-modify-write read gives a one-cycle `q_block` pulse with its line on `q_line`, in the cycle its result first appears. A locked read-modify-write write gives a one-cycle `q_unblock` pulse in the same way.
- R9: With `test_mode` high at acceptance, no reservation is set or cleared, every result is 1, and the block/unblock pulses still occur.
- R10: `inv_valid` clears every reservation on `inv_line`. An invalidation in the same cycle as an accepted completion takes effect before that completion.
  - A store-conditional to that line therefore fails.
  - A load-linked to that line still leaves a valid reservation.
- R11: `res_id` returns the requester ID of the completion that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Bypass reservation handling and force success |
| cmp_valid | input | 1 | Completion valid |
| cmp_ready | output | 1 | Completion ready |
| cmp_op | input | 3 | Operation code |
| cmp_id | input | ID_W (2) | Requester ID |
| cmp_line | input | LINE_W (26) | Line address |
| inv_valid | input | 1 | Invalidation or eviction of a line |
| inv_line | input | LINE_W (26) | Invalidated line address |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken |
| res_data | output | DATA_W (64) | Result word, 1 or 0 |
| res_id | output | ID_W (2) | Requester of the result |
| q_block | output | 1 | Block controller queue for `q_line` |
| q_unblock | output | 1 | Unblock controller queue for `q_line` |
| q_line | output | LINE_W (26) | Line for the block/unblock pulse |

## Verification
The hardest situation to create is an invalidation that lands in the exact cycle a store-conditional or load-linked to the same line is accepted. The stimulus handles this by driving `inv_valid` together with `cmp_valid` in one directed step for each case, and by letting the random phase raise the invalidation at acceptance over a line set of only four addresses. A second hard case is one requester's store-conditional wiping out another requester's reservation on the same line. It is reached with two load-linked operations to one line before the store-conditional. Random stalls on `res_ready` cover stability of a held result.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    OP_STORE     = 3'd0,
    OP_RMW_RD    = 3'd1,
    OP_RMW_WR    = 3'd2,
    OP_LL        = 3'd3,
    OP_SC        = 3'd4,
    OP_LOCK_RD   = 3'd5,
    OP_LOCK_WR   = 3'd6,
    OP_RSVD      = 3'd7
  } llsc_op_e;

  typedef struct packed {
    logic set_en;
    logic clr_line_en;
    logic clr_own_en;
    logic ok;
    logic blk;
    logic unblk;
  } llsc_action_t;
endpackage

// File: rtl/llsc_resv_bank.sv
module llsc_resv_bank #(
  parameter int NREQ   = 4,
  parameter int LINE_W = 26,
  parameter int ID_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         inv_valid,
  input  logic [LINE_W-1:0]            inv_line,
  input  logic                         set_en,
  input  logic                         clr_line_en,
  input  logic                         clr_own_en,
  input  logic [ID_W-1:0]              upd_id,
  input  logic [LINE_W-1:0]            upd_line,
  output logic [NREQ-1:0]              eff_valid,
  output logic [NREQ-1:0][LINE_W-1:0]  resv_line
);
  logic [NREQ-1:0] valid_q;

  for (genvar g = 0; g < NREQ; g++) begin : g_slot
    logic snooped;
    logic same_line;
    logic is_owner;

    always_comb begin
      snooped      = inv_valid && (resv_line[g] == inv_line);
      eff_valid[g] = valid_q[g] && !snooped;
      same_line    = resv_line[g] == upd_line;
      is_owner     = upd_id == ID_W'(g);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g]   <= 1'b0;
        resv_line[g] <= '0;
      end else if (set_en && is_owner) begin
        valid_q[g]   <= 1'b1;
        resv_line[g] <= upd_line;
      end else if (clr_line_en && same_line) begin
        valid_q[g]   <= 1'b0;
      end else if (clr_own_en && is_owner && same_line) begin
        valid_q[g]   <= 1'b0;
      end else begin
        valid_q[g]   <= eff_valid[g];
      end
    end
  end
endmodule

// File: rtl/llsc_decide.sv
module llsc_decide
  import llsc_pkg::*;
#(
  parameter int NREQ   = 4,
  parameter int LINE_W = 26,
  parameter int ID_W   = 2
) (
  input  llsc_op_e                     op,
  input  logic [ID_W-1:0]              id,
  input  logic [LINE_W-1:0]            line,
  input  logic                         test_mode,
  input  logic [NREQ-1:0]              eff_valid,
  input  logic [NREQ-1:0][LINE_W-1:0]  resv_line,
  output llsc_action_t                 act
);
  logic own_hit;

  always_comb begin
    own_hit = eff_valid[id] && (resv_line[id] == line);
    act = '0;
    act.ok    = 1'b1;
    act.blk   = (op == OP_LOCK_RD);
    act.unblk = (op == OP_LOCK_WR);
    if (!test_mode) begin
      unique case (op)
        OP_LL: act.set_en = 1'b1;
        OP_SC: begin
          act.clr_line_en = 1'b1;
          act.ok          = own_hit;
        end
        default: act.clr_own_en = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/llsc_result_slot.sv
module llsc_result_slot #(
  parameter int DATA_W = 64,
  parameter int LINE_W = 26,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              ok,
  input  logic [ID_W-1:0]   id,
  input  logic              blk,
  input  logic              unblk,
  input  logic [LINE_W-1:0] line,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [ID_W-1:0]   res_id,
  output logic              q_block,
  output logic              q_unblock,
  output logic [LINE_W-1:0] q_line
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_id    <= '0;
      q_block   <= 1'b0;
      q_unblock <= 1'b0;
      q_line    <= '0;
    end else begin
      q_block   <= load && blk;
      q_unblock <= load && unblk;
      if (load) begin
        res_valid <= 1'b1;
        res_data  <= DATA_W'(ok);
        res_id    <= id;
        q_line    <= line;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NREQ   = 4,
  parameter int LINE_W = 26,
  parameter int DATA_W = 64,
  parameter int ID_W   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [2:0]        cmp_op,
  input  logic [ID_W-1:0]   cmp_id,
  input  logic [LINE_W-1:0] cmp_line,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic [ID_W-1:0]   res_id,
  output logic              q_block,
  output logic              q_unblock,
  output logic [LINE_W-1:0] q_line
);
  logic                        accept;
  logic [NREQ-1:0]             eff_valid;
  logic [NREQ-1:0][LINE_W-1:0] resv_line;
  llsc_action_t                act;

  assign cmp_ready = !res_valid || res_ready;
  assign accept    = cmp_valid && cmp_ready;

  llsc_decide #(.NREQ(NREQ), .LINE_W(LINE_W), .ID_W(ID_W)) u_decide (
    .op        (llsc_op_e'(cmp_op)),
    .id        (cmp_id),
    .line      (cmp_line),
    .test_mode (test_mode),
    .eff_valid (eff_valid),
    .resv_line (resv_line),
    .act       (act)
  );

  llsc_resv_bank #(.NREQ(NREQ), .LINE_W(LINE_W), .ID_W(ID_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .inv_valid   (inv_valid),
    .inv_line    (inv_line),
    .set_en      (accept && act.set_en),
    .clr_line_en (accept && act.clr_line_en),
    .clr_own_en  (accept && act.clr_own_en),
    .upd_id      (cmp_id),
    .upd_line    (cmp_line),
    .eff_valid   (eff_valid),
    .resv_line   (resv_line)
  );

  llsc_result_slot #(.DATA_W(DATA_W), .LINE_W(LINE_W), .ID_W(ID_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .ok        (act.ok),
    .id        (cmp_id),
    .blk       (act.blk),
    .unblk     (act.unblk),
    .line      (cmp_line),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_id    (res_id),
    .q_block   (q_block),
    .q_unblock (q_unblock),
    .q_line    (q_line)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NREQ   = 4,
  parameter int LINE_W = 26,
  parameter int DATA_W = 64,
  parameter int ID_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_mode,
  input logic              cmp_valid,
  input logic              cmp_ready,
  input logic [2:0]        cmp_op,
  input logic [ID_W-1:0]   cmp_id,
  input logic [LINE_W-1:0] cmp_line,
  input logic              inv_valid,
  input logic [LINE_W-1:0] inv_line,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic [ID_W-1:0]   res_id,
  input logic              q_block,
  input logic              q_unblock,
  input logic [LINE_W-1:0] q_line
);
  logic            acc_q;
  logic [2:0]      op_q;
  logic            tm_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      op_q  <= '0;
      tm_q  <= 1'b0;
      id_q  <= '0;
    end else begin
      acc_q <= cmp_valid && cmp_ready;
      op_q  <= cmp_op;
      tm_q  <= test_mode;
      id_q  <= cmp_id;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_id));
  a_r2_stall: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !cmp_ready);
  a_r4_ll_ok: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q && op_q == 3'd3 |-> res_valid && res_data == DATA_W'(1));
  a_r9_test_ok: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q && tm_q |-> res_data == DATA_W'(1));
  a_r8_block_src: assert property (@(posedge clk) disable iff (!rst_n)
    q_block |-> acc_q && op_q == 3'd5);
  a_r8_unblock_src: assert property (@(posedge clk) disable iff (!rst_n)
    q_unblock |-> acc_q && op_q == 3'd6);
  a_r5_binary: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_data <= DATA_W'(1));
  a_r11_id: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> res_valid && res_id == id_q);
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .NREQ(NREQ), .LINE_W(LINE_W), .DATA_W(DATA_W), .ID_W(ID_W)
) u_chk (.*);

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
  localparam int NREQ = 4, LINE_W = 26, DATA_W = 64, ID_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic test_mode = 1'b0, cmp_valid = 1'b0, cmp_ready;
  logic [2:0] cmp_op = '0;
  logic [ID_W-1:0] cmp_id = '0;
  logic [LINE_W-1:0] cmp_line = '0, inv_line = '0, q_line;
  logic inv_valid = 1'b0, res_valid, res_ready = 1'b1, q_block, q_unblock;
  logic [DATA_W-1:0] res_data;
  logic [ID_W-1:0] res_id;

  int errors = 0, checks = 0;
  logic ref_v [NREQ];
  logic [LINE_W-1:0] ref_l [NREQ];

  always #2 clk = ~clk;

  llsc_monitor u0 (.*);

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [2:0] op, input int id,
      input logic [LINE_W-1:0] ln, input logic inv, input logic [LINE_W-1:0] il, input logic tm);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NREQ; i++) if (inv && ref_v[i] && ref_l[i] == il) ref_v[i] = 1'b0;
    if (!tm) begin
      if (op == 3'd3) begin
        ref_v[id] = 1'b1; ref_l[id] = ln;
      end else if (op == 3'd4) begin
        ok = ref_v[id] && ref_l[id] == ln;
        for (int i = 0; i < NREQ; i++) if (ref_v[i] && ref_l[i] == ln) ref_v[i] = 1'b0;
      end else if (ref_v[id] && ref_l[id] == ln) begin
        ref_v[id] = 1'b0;
      end
    end
    return {1'b0, ok};
  endfunction

  task automatic do_op(input logic [2:0] op, input int id, input logic [LINE_W-1:0] ln,
      input logic inv, input logic [LINE_W-1:0] il, input logic tm, input int stall, input string req);
    logic exp_ok;
    exp_ok = model(op, id, ln, inv, il, tm)[0];
    @(negedge clk);
    cmp_valid = 1'b1; cmp_op = op; cmp_id = ID_W'(id); cmp_line = ln;
    inv_valid = inv; inv_line = il; test_mode = tm; res_ready = (stall == 0);
    @(negedge clk);
    cmp_valid = 1'b0; inv_valid = 1'b0; test_mode = 1'b0;
    chk(res_valid === 1'b1, {req, " R2 valid"}, res_valid, 1);
    chk(res_data === DATA_W'(exp_ok), {req, " result"}, res_data, exp_ok);
    chk(res_id === ID_W'(id), {req, " R11 id"}, res_id, id);
    chk(q_block === (op == 3'd5), {req, " R8 block"}, q_block, op == 3'd5);
    chk(q_unblock === (op == 3'd6), {req, " R8 unblock"}, q_unblock, op == 3'd6);
    if (op == 3'd5 || op == 3'd6) chk(q_line === ln, {req, " R8 line"}, q_line, ln);
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      chk(res_valid === 1'b1 && res_data === DATA_W'(exp_ok) && cmp_ready === 1'b0,
          {req, " R2 hold"}, res_data, exp_ok);
      chk(q_block === 1'b0 && q_unblock === 1'b0, {req, " R8 pulse"}, q_block, 0);
      res_ready = 1'b1;
    end
    @(negedge clk);
    chk(res_valid === 1'b0 && cmp_ready === 1'b1, {req, " R2 drain"}, res_valid, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREQ; i++) begin ref_v[i] = 1'b0; ref_l[i] = '0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(res_valid === 1'b0 && q_block === 1'b0 && q_unblock === 1'b0 && cmp_ready === 1'b1,
        "R1 reset outputs", res_valid, 0);
    rst_n = 1'b1;
    // R1: no reservation after reset, so a store-conditional fails
    do_op(3'd4, 0, 26'h10, 0, 0, 0, 0, "R1_sc_after_reset");
    // R4 / R5 basic success, then R6 clear makes a repeat fail
    do_op(3'd3, 1, 26'h20, 0, 0, 0, 0, "R4_ll");
    do_op(3'd4, 1, 26'h20, 0, 0, 0, 0, "R5_sc_ok");
    do_op(3'd4, 1, 26'h20, 0, 0, 0, 0, "R6_sc_again");
    // R4 overwrite of prior reservation
    do_op(3'd3, 2, 26'h30, 0, 0, 0, 0, "R4_ll_a");
    do_op(3'd3, 2, 26'h31, 0, 0, 0, 0, "R4_ll_b");
    do_op(3'd4, 2, 26'h30, 0, 0, 0, 0, "R4_sc_old_line");
    // R6 SC by one requester clears another's reservation on same line
    do_op(3'd3, 0, 26'h40, 0, 0, 0, 0, "R6_ll0");
    do_op(3'd3, 1, 26'h40, 0, 0, 0, 0, "R6_ll1");
    do_op(3'd4, 1, 26'h40, 0, 0, 0, 0, "R6_sc1");
    do_op(3'd4, 0, 26'h40, 0, 0, 0, 0, "R6_sc0_lost");
    // R7 other requester's store keeps, own store clears
    do_op(3'd3, 0, 26'h50, 0, 0, 0, 0, "R7_ll");
    do_op(3'd0, 1, 26'h50, 0, 0, 0, 0, "R7_store_other");
    do_op(3'd4, 0, 26'h50, 0, 0, 0, 0, "R7_sc_kept");
    do_op(3'd3, 0, 26'h51, 0, 0, 0, 0, "R7_ll2");
    do_op(3'd7, 0, 26'h51, 0, 0, 0, 0, "R3_code7_own");
    do_op(3'd4, 0, 26'h51, 0, 0, 0, 0, "R7_sc_cleared");
    // R10 invalidation alone, and same cycle as SC / LL
    do_op(3'd3, 3, 26'h60, 0, 0, 0, 0, "R10_ll");
    do_op(3'd0, 2, 26'h61, 1, 26'h60, 0, 0, "R10_inv");
    do_op(3'd4, 3, 26'h60, 0, 0, 0, 0, "R10_sc_after_inv");
    do_op(3'd3, 3, 26'h62, 0, 0, 0, 0, "R10_ll2");
    do_op(3'd4, 3, 26'h62, 1, 26'h62, 0, 0, "R10_sc_with_inv");
    do_op(3'd3, 3, 26'h63, 1, 26'h63, 0, 0, "R10_ll_with_inv");
    do_op(3'd4, 3, 26'h63, 0, 0, 0, 0, "R10_sc_ok");
    // R9 test mode
    do_op(3'd4, 2, 26'h70, 0, 0, 1, 0, "R9_sc_forced");
    do_op(3'd3, 2, 26'h70, 0, 0, 1, 0, "R9_ll_noset");
    do_op(3'd4, 2, 26'h70, 0, 0, 0, 0, "R9_sc_real");
    do_op(3'd5, 2, 26'h71, 0, 0, 1, 0, "R9_block_tm");
    // R8 block/unblock, R2 back-pressure
    do_op(3'd5, 1, 26'h80, 0, 0, 0, 2, "R8_lock_rd");
    do_op(3'd6, 1, 26'h80, 0, 0, 0, 3, "R8_lock_wr");
    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) op = 3'd3;
      do_op(op, int'($urandom_range(0, NREQ - 1)), LINE_W'($urandom_range(0, 3)),
            ($urandom_range(0, 5) == 0), LINE_W'($urandom_range(0, 3)),
            ($urandom_range(0, 9) == 0), (($urandom_range(0, 4) == 0) ? 2 : 0), "R5_random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule